// File: doc/BRIEF.md
# UDP Command Frame Decoder

This block watches the byte stream coming out of an Ethernet MAC receiver and picks out IPv4/UDP datagrams that are addressed to this node. Each datagram it accepts becomes one register write. The destination UDP port number is used directly as the register address. The first payload bytes, read as a big-endian word, are the write data. A host on a controlled local network can therefore set registers by sending small UDP packets. It needs a static address-resolution entry for this node and must not use IP options or fragmentation.

Fields are located by position, not by parsing. A byte counter restarts on every start-of-frame byte, and each header field is compared at its fixed offset from the first destination-MAC byte. If any comparison fails, the write is dropped. The same happens if the MAC flags an error or the frame ends too early. No trace of a dropped frame reaches the outputs.

Top module: `udp_cmd_decoder`

## Requirements
- R1: After reset, `wr_en` is low and `wr_addr` and `wr_data` are zero.
- R2: For a matching frame, `wr_en` is high for exactly the one cycle after the clock edge that takes the end-of-frame byte. `wr_addr` then equals the destination port (offset 36 = high byte, 37 = low byte). `wr_data` equals payload bytes 42..45, with byte 42 as the most significant.
- R3: Bytes at offsets 12 and 13 must be 0x08 and 0x00, otherwise no write takes place.
- R4: The byte at offset 14 must be exactly 0x45 (version 4, five-word header), otherwise no write takes place.
- R5: Fragments are refused. A write requires bits 5..0 of offset 20 and all of offset 21 to be zero. Bits 7 and 6 of offset 20 (reserved and don't-fragment) have no effect.
- R6: The byte at offset 23 must be 17, otherwise no write takes place.
- R7: Bytes 30..33 must equal `node_ip`, with byte 30 compared against `node_ip[31:24]`; otherwise no write takes place.
- R8: A frame must have at least MIN_FRAME_BYTES (46) valid bytes. A 45-byte frame is refused and a 46-byte frame is accepted.
- R9: If `rx_err` is high on any valid byte of the frame, including the end-of-frame byte, no write takes place.
- R10: The UDP checksum bytes (offsets 40 and 41) have no effect. Zero and nonzero values are both accepted.
- R11: Cycles with `rx_valid` low do not advance the byte position. A frame with idle gaps decodes the same as a frame without them.
- R12: A start-of-frame byte always restarts decoding at offset 0, even in the middle of a frame. Valid bytes that arrive after an end-of-frame and before the next start-of-frame are ignored, including any end-of-frame flag among them.
- R13: Outside the cases in R2, `wr_en` stays low, and `wr_addr` and `wr_data` keep their last written values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A byte is present on `rx_data` this cycle |
| rx_sof | input | 1 | The byte is the first byte of a frame |
| rx_eof | input | 1 | The byte is the last byte of a frame |
| rx_err | input | 1 | The MAC flags an error on this byte |
| rx_data | input | 8 | Received byte |
| node_ip | input | 32 | IPv4 address of this node, used for matching |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | ADDR_W | Register address (UDP destination port) |
| wr_data | output | DATA_W | Register write data (first payload bytes) |

## Verification
The bench builds the decoder with its default parameters: a 16-bit address, a 32-bit data word and a 46-byte minimum frame. With this configuration, the end-of-frame byte can coincide with the last data byte, so the bypass path of the capture logic is exercised. Every value from 0 to 255 is swept through the protocol byte, the version byte, the EtherType high byte and both fragment bytes. For each value, the bench predicts acceptance arithmetically. Frame length is swept across the 46-byte boundary. The error flag is placed on every byte position in turn. All 32 single-bit mismatches of the node address are tried. Separate cases cover idle gaps, restarts in the middle of a frame and bytes that arrive outside any frame.

// File: rtl/udp_cmd_pkg.sv
package udp_cmd_pkg;
   // byte offsets counted from the first destination-MAC byte
   localparam int OFS_ETYPE_HI  = 12;
   localparam int OFS_ETYPE_LO  = 13;
   localparam int OFS_VER_IHL   = 14;
   localparam int OFS_FRAG_HI   = 20;
   localparam int OFS_FRAG_LO   = 21;
   localparam int OFS_PROTO     = 23;
   localparam int OFS_DST_IP    = 30;
   localparam int OFS_DST_PORT  = 36;
   localparam int OFS_PAYLOAD   = 42;
   localparam int PORT_BYTES    = 2;
   localparam int IP_BYTES      = 4;

   localparam logic [7:0] ETYPE_HI_IPV4 = 8'h08;
   localparam logic [7:0] ETYPE_LO_IPV4 = 8'h00;
   localparam logic [7:0] VER_IHL_PLAIN = 8'h45;
   localparam logic [7:0] PROTO_UDP     = 8'd17;
   // more-fragments flag and upper offset bits
   localparam logic [7:0] FRAG_HI_MASK  = 8'h3F;
endpackage

// File: rtl/frame_pos_counter.sv
module frame_pos_counter #(
   parameter int MAX_COUNT = 46,
   localparam int CNT_W = $clog2(MAX_COUNT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             beat_valid,
   input  logic             beat_sof,
   input  logic             beat_eof,
   output logic [CNT_W-1:0] idx,
   output logic             take
);
   logic [CNT_W-1:0] cnt_q;
   logic             in_frame_q;
   logic [CNT_W-1:0] cnt_nxt;

   assign idx     = beat_sof ? '0 : cnt_q;
   assign take    = beat_valid && (beat_sof || in_frame_q);
   assign cnt_nxt = (idx == CNT_W'(MAX_COUNT)) ? idx : idx + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         in_frame_q <= 1'b0;
      end else if (take) begin
         cnt_q      <= cnt_nxt;
         in_frame_q <= !beat_eof;
      end
   end

   a_r11_gap_holds_position: assert property (@(posedge clk) disable iff (!rst_n)
      !beat_valid |=> $stable(cnt_q));
   a_r12_sof_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && beat_sof) |=> (cnt_q == CNT_W'(1)));
   a_r12_eof_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (take && beat_eof) |=> !in_frame_q);
endmodule

// File: rtl/udp_hdr_check.sv
module udp_hdr_check
   import udp_cmd_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             sof,
   input  logic             err,
   input  logic [CNT_W-1:0] idx,
   input  logic [7:0]       byte_in,
   input  logic [31:0]      node_ip,
   output logic             ok_now
);
   logic ok_q;
   logic byte_ok;
   int   pos;

   always_comb begin
      pos     = int'(idx);
      byte_ok = 1'b1;
      if (pos == OFS_ETYPE_HI) byte_ok = (byte_in == ETYPE_HI_IPV4);
      if (pos == OFS_ETYPE_LO) byte_ok = (byte_in == ETYPE_LO_IPV4);
      if (pos == OFS_VER_IHL)  byte_ok = (byte_in == VER_IHL_PLAIN);
      if (pos == OFS_FRAG_HI)  byte_ok = ((byte_in & FRAG_HI_MASK) == 8'h00);
      if (pos == OFS_FRAG_LO)  byte_ok = (byte_in == 8'h00);
      if (pos == OFS_PROTO)    byte_ok = (byte_in == PROTO_UDP);
      for (int k = 0; k < IP_BYTES; k++) begin
         if (pos == OFS_DST_IP + k) byte_ok = (byte_in == node_ip[8*(IP_BYTES-1-k) +: 8]);
      end
   end

   assign ok_now = (sof ? 1'b1 : ok_q) && byte_ok && !err;

   always_ff @(posedge clk) begin
      if (!rst_n)    ok_q <= 1'b0;
      else if (take) ok_q <= ok_now;
   end

   a_r9_err_spoils_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (take && err) |=> !ok_q);
   a_r9_spoiled_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !sof && !ok_q) |=> !ok_q);
endmodule

// File: rtl/byte_field_capture.sv
module byte_field_capture #(
   parameter int CNT_W  = 6,
   parameter int OFS    = 36,
   parameter int NBYTES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take,
   input  logic [CNT_W-1:0]    idx,
   input  logic [7:0]          byte_in,
   output logic [8*NBYTES-1:0] field_now
);
   int pos;
   assign pos = int'(idx);

   for (genvar g = 0; g < NBYTES; g++) begin : g_lane
      localparam int LANE_POS = OFS + g;
      logic [7:0] lane_q;
      logic       hit;

      assign hit = take && (pos == LANE_POS);

      always_ff @(posedge clk) begin
         if (!rst_n)   lane_q <= 8'h00;
         else if (hit) lane_q <= byte_in;
      end

      // first byte on the wire is the most significant
      assign field_now[8*(NBYTES-1-g) +: 8] = hit ? byte_in : lane_q;
   end
endmodule

// File: rtl/udp_cmd_decoder.sv
module udp_cmd_decoder
   import udp_cmd_pkg::*;
#(
   parameter int ADDR_W          = 16,
   parameter int DATA_W          = 32,
   parameter int MIN_FRAME_BYTES = 46
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic              rx_sof,
   input  logic              rx_eof,
   input  logic              rx_err,
   input  logic [7:0]        rx_data,
   input  logic [31:0]       node_ip,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   localparam int DATA_BYTES = DATA_W / 8;
   localparam int CNT_W      = $clog2(MIN_FRAME_BYTES + 1);

   initial begin : p_param_checks
      assert (DATA_W % 8 == 0 && DATA_W >= 8) else $fatal(1, "DATA_W must be a whole number of bytes");
      assert (ADDR_W >= 1 && ADDR_W <= 16) else $fatal(1, "ADDR_W must be 1..16");
      assert (MIN_FRAME_BYTES >= OFS_PAYLOAD + DATA_BYTES)
         else $fatal(1, "MIN_FRAME_BYTES must cover the payload word");
   end

   logic [CNT_W-1:0]        idx;
   logic                    take;
   logic                    ok_now;
   logic [8*PORT_BYTES-1:0] port_now;
   logic [DATA_W-1:0]       data_now;
   logic [ADDR_W-1:0]       addr_now;
   logic                    long_enough;
   logic                    fire;

   frame_pos_counter #(.MAX_COUNT(MIN_FRAME_BYTES)) u_pos (
      .clk       (clk),
      .rst_n     (rst_n),
      .beat_valid(rx_valid),
      .beat_sof  (rx_sof),
      .beat_eof  (rx_eof),
      .idx       (idx),
      .take      (take)
   );

   udp_hdr_check #(.CNT_W(CNT_W)) u_hdr (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (take),
      .sof    (rx_sof),
      .err    (rx_err),
      .idx    (idx),
      .byte_in(rx_data),
      .node_ip(node_ip),
      .ok_now (ok_now)
   );

   byte_field_capture #(.CNT_W(CNT_W), .OFS(OFS_DST_PORT), .NBYTES(PORT_BYTES)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .idx      (idx),
      .byte_in  (rx_data),
      .field_now(port_now)
   );

   byte_field_capture #(.CNT_W(CNT_W), .OFS(OFS_PAYLOAD), .NBYTES(DATA_BYTES)) u_data (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .idx      (idx),
      .byte_in  (rx_data),
      .field_now(data_now)
   );

   if (ADDR_W == 8 * PORT_BYTES) begin : g_addr_full
      assign addr_now = port_now;
   end else begin : g_addr_trim
      logic [8*PORT_BYTES-ADDR_W-1:0] unused_hi;
      assign unused_hi = port_now[8*PORT_BYTES-1:ADDR_W];
      assign addr_now  = port_now[ADDR_W-1:0];
   end

   assign long_enough = int'(idx) >= MIN_FRAME_BYTES - 1;
   assign fire        = take && rx_eof && ok_now && long_enough;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= fire;
         if (fire) begin
            wr_addr <= addr_now;
            wr_data <= data_now;
         end
      end
   end

   a_r13_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);
   a_r2_follows_eof: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(rx_valid && rx_eof));
   a_r9_no_write_on_err: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !$past(rx_valid && rx_err));
   a_r13_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> ($stable(wr_addr) && $stable(wr_data)));
endmodule

// File: tb/udp_cmd_decoder_tb.sv
module udp_cmd_decoder_tb;
   localparam int          CLK_PERIOD = 10;
   localparam logic [31:0] NODE       = 32'hC0A8_0A07;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
   logic [7:0]  rx_data = 8'h00;
   logic [31:0] node_ip = NODE;
   logic        wr_en;
   logic [15:0] wr_addr;
   logic [31:0] wr_data;

   int checks = 0;
   int fails  = 0;
   int seq    = 0;
   int flen   = 0;
   logic [7:0]  frm [0:79];
   logic [15:0] exp_port, last_addr = 16'h0;
   logic [31:0] exp_data, last_data = 32'h0;

   always #(CLK_PERIOD/2) clk = ~clk;

   udp_cmd_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
      .rx_err(rx_err), .rx_data(rx_data), .node_ip(node_ip),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic build(input int len);
      seq++;
      exp_port = 16'h0100 + 16'(seq);
      exp_data = {8'hC3, 8'(seq), 8'(seq * 7), 8'h5A};
      for (int i = 0; i < 80; i++) frm[i] = 8'(i * 13 + 1);
      frm[12] = 8'h08; frm[13] = 8'h00; frm[14] = 8'h45;
      frm[20] = 8'h40; frm[21] = 8'h00; frm[23] = 8'd17;
      for (int k = 0; k < 4; k++) frm[30+k] = NODE[8*(3-k) +: 8];
      frm[36] = exp_port[15:8]; frm[37] = exp_port[7:0];
      frm[40] = 8'h00; frm[41] = 8'h00;
      for (int k = 0; k < 4; k++) frm[42+k] = exp_data[8*(3-k) +: 8];
      flen = len;
   endtask

   task automatic idle();
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
   endtask

   // bytes are driven on falling edges; returns on the falling edge after the last byte
   task automatic drive_frame(input int gap, input int err_at, input bit with_sof);
      for (int i = 0; i < flen; i++) begin
         if (gap > 0 && (i % gap) == gap - 1) begin
            @(negedge clk); idle();
         end
         @(negedge clk);
         rx_valid = 1'b1;
         rx_sof   = with_sof && (i == 0);
         rx_eof   = (i == flen - 1);
         rx_err   = (i == err_at);
         rx_data  = frm[i];
      end
      @(negedge clk);
      idle();
   endtask

   task automatic judge(input bit expect_ok, input string tag);
      if (expect_ok) begin
         chk(wr_en === 1'b1, {tag, " strobe"}, 64'(wr_en), 64'd1);
         chk(wr_addr === exp_port, {tag, " R2 addr"}, 64'(wr_addr), 64'(exp_port));
         chk(wr_data === exp_data, {tag, " R2 data"}, 64'(wr_data), 64'(exp_data));
         last_addr = exp_port; last_data = exp_data;
      end else begin
         chk(wr_en === 1'b0, {tag, " no strobe"}, 64'(wr_en), 64'd0);
         chk({wr_addr, wr_data} === {last_addr, last_data}, {tag, " R13 held"},
             64'({wr_addr, wr_data}), 64'({last_addr, last_data}));
      end
      @(negedge clk);
      chk(wr_en === 1'b0, {tag, " R13 one cycle"}, 64'(wr_en), 64'd0);
      repeat (2) @(negedge clk);
   endtask

   task automatic run_case(input bit expect_ok, input string tag, input int gap, input int err_at);
      drive_frame(gap, err_at, 1'b1);
      judge(expect_ok, tag);
   endtask

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin : main
      repeat (4) @(negedge clk);
      chk(wr_en === 1'b0 && wr_addr === 16'h0 && wr_data === 32'h0, "R1 reset state",
          64'({wr_en, wr_addr, wr_data}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(wr_en === 1'b0 && wr_addr === 16'h0 && wr_data === 32'h0, "R1 after release",
          64'({wr_en, wr_addr, wr_data}), 64'd0);

      build(60); run_case(1'b1, "R2 basic", 0, -1);

      for (int v = 0; v < 256; v++) begin
         build(50); frm[12] = 8'(v);
         run_case(v == 8, $sformatf("R3 etype_hi=%02h", v), 0, -1);
      end
      build(50); frm[13] = 8'h06; run_case(1'b0, "R3 etype_lo", 0, -1);

      for (int v = 0; v < 256; v++) begin
         build(50); frm[14] = 8'(v);
         run_case(v == 8'h45, $sformatf("R4 ver_ihl=%02h", v), 0, -1);
      end

      for (int v = 0; v < 256; v++) begin
         build(50); frm[20] = 8'(v);
         run_case((v & 8'h3F) == 0, $sformatf("R5 frag_hi=%02h", v), 0, -1);
      end
      for (int v = 0; v < 256; v++) begin
         build(50); frm[21] = 8'(v);
         run_case(v == 0, $sformatf("R5 frag_lo=%02h", v), 0, -1);
      end

      for (int v = 0; v < 256; v++) begin
         build(50); frm[23] = 8'(v);
         run_case(v == 17, $sformatf("R6 proto=%02h", v), 0, -1);
      end

      for (int b = 0; b < 32; b++) begin
         build(50); frm[30 + (3 - b/8)] ^= 8'(1 << (b % 8));
         run_case(1'b0, $sformatf("R7 ip bit %0d", b), 0, -1);
      end
      build(50); run_case(1'b1, "R7 ip match", 0, -1);

      for (int len = 30; len <= 60; len++) begin
         build(len);
         run_case(len >= 46, $sformatf("R8 len=%0d", len), 0, -1);
      end

      for (int e = 0; e < 50; e++) begin
         build(50);
         run_case(1'b0, $sformatf("R9 err at %0d", e), 0, e);
      end
      build(46); run_case(1'b0, "R9 err on eof", 0, 45);

      build(50); frm[40] = 8'hFF; frm[41] = 8'hFF; run_case(1'b1, "R10 csum ffff", 0, -1);
      build(50); frm[40] = 8'h5A; frm[41] = 8'h3C; run_case(1'b1, "R10 csum 5a3c", 0, -1);
      build(50); run_case(1'b1, "R10 csum zero", 0, -1);

      build(50); run_case(1'b1, "R11 gap every 2", 2, -1);
      build(46); run_case(1'b1, "R11 gap every 3 min len", 3, -1);
      build(46); run_case(1'b0, "R11 err with gaps", 5, 44);

      // R12: abandoned partial frame, then a fresh start-of-frame
      build(60);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = 1'b0; rx_err = 1'b0; rx_data = frm[i];
      end
      run_case(1'b1, "R12 restart mid frame", 0, -1);
      // R12: well-formed bytes with no start-of-frame are ignored
      build(50);
      drive_frame(0, -1, 1'b0);
      judge(1'b0, "R12 no sof ignored");
      build(50); run_case(1'b1, "R12 recovers", 0, -1);

      summary();
      $finish;
   end
endmodule